// File: doc/BRIEF.md
# Four-Channel Interval Timer Bank

A bank of four independent down-counting timers behind a simple zero-wait-state APB-style register port. Each channel owns a 64-byte register window, a 32-bit counter, a stored load value, a run mode and its own interrupt line. Software programs a load value, picks continuous or single-shot operation, starts the channel and then reads the live count or services the interrupt.

Each channel has a pending flag that is set when its count expires. The flag drives the channel's interrupt line unless the channel's mask bit is set. Software clears the flag through a clear register that uses a two-cycle busy handshake. While a clear is completing, further clear writes are dropped. A block-wide status word at address 0x00 collects the pending flags of all channels.

A write takes effect at the rising clock edge where `psel`, `penable` and `pwrite` are all high. Read data is combinational from `paddr` and reflects the state after the most recent edge.

Top module: `interval_timer_bank`

## Requirements
- R1: After reset, every channel register reads 0, the status word reads 0 and all `irq` bits are low.
- R2: Channel n's registers lie at byte address n*0x40 + offset. The offsets are 0x04 mode, 0x08 load, 0x10 run enable, 0x14 reload, 0x18 count (read-only), 0x20 clear, 0x24 mask. A write to the load offset stores the value and also places it in the counter. While the run enable bit 0 is 1, the count drops by one at every edge, and it holds while the bit is 0.
- R3: An expiry is an edge at which the channel is enabled and its count is 0. At an expiry the pending flag becomes 1. With mode bit 0 equal to 0 (continuous), the counter takes the load value at the expiry, so expiries repeat every load+1 edges.
- R4: With mode bit 0 equal to 1 (single), an expiry leaves the count at 0 and clears the run enable bit.
- R5: A write of any data to the reload offset copies the stored load value into the counter, and takes priority over that edge's decrement.
- R6: Bit 0 of the clear register reads the pending flag. Writing 1 to it clears the flag, and writing 0 changes nothing.
- R7: After an accepted clear, bit 1 of the clear register reads 1 for exactly two cycles. Clear writes made while it is 1 are ignored.
- R8: An expiry at the same edge as an accepted clear leaves the pending flag set.
- R9: `irq[n]` is high exactly when channel n is pending and bit 0 of its mask register is 0. The mask never alters the pending flag.
- R10: The status word at address 0x00 carries channel n's pending flag in bit n and zeros above bit 3.
- R11: A write to one channel's window changes no register of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| irq | output | 4 | Per-channel interrupt, high = asserted |

## Verification
Continuous runs are swept over load values 0, 1, 2, 3 and 6 on rotating channels. The count and pending flag are compared every cycle against the arithmetic sequence load-(n mod (load+1)), which separates off-by-one period errors from reload errors. Single runs use a short load and the maximum load value, which tells a stopped counter apart from one that wraps. The clear path is driven into three timed situations: a clear on a quiet edge, a clear that coincides with an expiry, and a clear issued during the busy window. These distinguish the handshake from a plain write-one-to-clear. Mask and status checks use several channels pending at once, which exposes crossed channel indices.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register offsets inside one channel window (bytes)
    localparam int OFS_STATUS = 'h00;
    localparam int OFS_MODE   = 'h04;
    localparam int OFS_LOAD   = 'h08;
    localparam int OFS_RUN    = 'h10;
    localparam int OFS_RELOAD = 'h14;
    localparam int OFS_COUNT  = 'h18;
    localparam int OFS_CLEAR  = 'h20;
    localparam int OFS_MASK   = 'h24;

    // Per-channel write strobes produced by the decoder
    typedef struct packed {
        logic mode;
        logic load;
        logic run;
        logic reload;
        logic clear;
        logic mask;
    } tmr_wr_t;

    localparam tmr_wr_t TMR_WR_NONE = '0;

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 6
) (
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    output tmr_wr_t [NUM_CH-1:0]       wr_v
);
    localparam int CH_W = ADDR_W - OFS_W;

    logic [CH_W-1:0]  ch_f;
    logic [OFS_W-1:0] ofs_f;

    assign ch_f  = addr[ADDR_W-1:OFS_W];
    assign ofs_f = addr[OFS_W-1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        logic hit;
        assign hit = wr_en && (ch_f == CH_W'(g));
        always_comb begin
            wr_v[g] = TMR_WR_NONE;
            if (hit) begin
                wr_v[g].mode   = (ofs_f == OFS_W'(OFS_MODE));
                wr_v[g].load   = (ofs_f == OFS_W'(OFS_LOAD));
                wr_v[g].run    = (ofs_f == OFS_W'(OFS_RUN));
                wr_v[g].reload = (ofs_f == OFS_W'(OFS_RELOAD));
                wr_v[g].clear  = (ofs_f == OFS_W'(OFS_CLEAR));
                wr_v[g].mask   = (ofs_f == OFS_W'(OFS_MASK));
            end
        end
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  tmr_wr_t           wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              mode,
    output logic              run,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic              expire
);
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cnt_q;
    logic              mode_q;
    logic              run_q;

    assign expire   = run_q && (cnt_q == '0);
    assign mode     = mode_q;
    assign run      = run_q;
    assign load_val = load_q;
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            cnt_q  <= '0;
            mode_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (wr.mode) mode_q <= wdata[0];
            if (wr.load) load_q <= wdata;

            // counter: explicit loads first, then the running path
            if (wr.load) begin
                cnt_q <= wdata;
            end else if (wr.reload) begin
                cnt_q <= load_q;
            end else if (expire) begin
                cnt_q <= mode_q ? '0 : load_q;
            end else if (run_q) begin
                cnt_q <= cnt_q - 1'b1;
            end

            // a software write to the run bit wins over the single-shot stop
            if (wr.run) begin
                run_q <= wdata[0];
            end else if (expire && mode_q) begin
                run_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
    import tmr_pkg::*;
#(
    parameter int BUSY_CYC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  tmr_wr_t wr,
    input  logic    wbit,
    input  logic    expire,
    output logic    pend,
    output logic    busy,
    output logic    mask,
    output logic    irq
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [BW-1:0] bcnt_q;
    logic          pend_q;
    logic          mask_q;
    logic          clr_ok;

    assign clr_ok = wr.clear && wbit && (bcnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q <= '0;
            pend_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            // a fresh expiry outranks a clear on the same edge
            if (expire) begin
                pend_q <= 1'b1;
            end else if (clr_ok) begin
                pend_q <= 1'b0;
            end

            if (clr_ok) begin
                bcnt_q <= BW'(BUSY_CYC);
            end else if (bcnt_q != '0) begin
                bcnt_q <= bcnt_q - 1'b1;
            end

            if (wr.mask) mask_q <= wbit;
        end
    end

    assign pend = pend_q;
    assign busy = (bcnt_q != '0);
    assign mask = mask_q;
    assign irq  = pend_q & ~mask_q;

endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int DATA_W       = 32,
    parameter int WIN_BYTES    = 64,
    parameter int ADDR_W       = 8,
    parameter int CLR_BUSY_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int OFS_W = $clog2(WIN_BYTES);
    localparam int CH_W  = ADDR_W - OFS_W;

    logic                          bus_wr;
    tmr_wr_t [NUM_CH-1:0]          wr_v;
    logic [NUM_CH-1:0]             mode_v;
    logic [NUM_CH-1:0]             en_v;
    logic [NUM_CH-1:0]             exp_v;
    logic [NUM_CH-1:0]             pend_v;
    logic [NUM_CH-1:0]             busy_v;
    logic [NUM_CH-1:0]             mask_v;
    logic [NUM_CH-1:0][DATA_W-1:0] load_v;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_v;

    assign bus_wr = psel && penable && pwrite;

    tmr_regdec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) dec_i (
        .wr_en (bus_wr),
        .addr  (paddr),
        .wr_v  (wr_v)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_count #(
            .DATA_W (DATA_W)
        ) cnt_i (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr_v[g]),
            .wdata    (pwdata),
            .mode     (mode_v[g]),
            .run      (en_v[g]),
            .load_val (load_v[g]),
            .count    (cnt_v[g]),
            .expire   (exp_v[g])
        );

        tmr_irq_ctl #(
            .BUSY_CYC (CLR_BUSY_CYC)
        ) irq_i (
            .clk    (clk),
            .rst    (rst),
            .wr     (wr_v[g]),
            .wbit   (pwdata[0]),
            .expire (exp_v[g]),
            .pend   (pend_v[g]),
            .busy   (busy_v[g]),
            .mask   (mask_v[g]),
            .irq    (irq[g])
        );
    end

    // read path
    logic [CH_W-1:0]  rd_ch;
    logic [OFS_W-1:0] rd_ofs;

    assign rd_ch  = paddr[ADDR_W-1:OFS_W];
    assign rd_ofs = paddr[OFS_W-1:0];

    always_comb begin
        prdata = '0;
        if (paddr == ADDR_W'(OFS_STATUS)) begin
            prdata[NUM_CH-1:0] = pend_v;
        end else if (int'(rd_ch) < NUM_CH) begin
            case (int'(rd_ofs))
                OFS_MODE:  prdata[0]   = mode_v[rd_ch];
                OFS_LOAD:  prdata      = load_v[rd_ch];
                OFS_RUN:   prdata[0]   = en_v[rd_ch];
                OFS_COUNT: prdata      = cnt_v[rd_ch];
                OFS_CLEAR: prdata[1:0] = {busy_v[rd_ch], pend_v[rd_ch]};
                OFS_MASK:  prdata[0]   = mask_v[rd_ch];
                default:   prdata      = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_wr,
    input logic [NUM_CH-1:0]             irq,
    input logic [NUM_CH-1:0]             pend_v,
    input logic [NUM_CH-1:0]             mask_v,
    input logic [NUM_CH-1:0]             busy_v,
    input logic [NUM_CH-1:0]             en_v,
    input logic [NUM_CH-1:0]             mode_v,
    input logic [NUM_CH-1:0][DATA_W-1:0] cnt_v
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R2
        cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
            (en_v[g] && cnt_v[g] != '0 && !bus_wr) |=> (cnt_v[g] == $past(cnt_v[g]) - 1'b1));

        // R3
        expire_pend_chk: assert property (@(posedge clk) disable iff (rst)
            (en_v[g] && cnt_v[g] == '0) |=> pend_v[g]);

        // R4
        single_stop_chk: assert property (@(posedge clk) disable iff (rst)
            (en_v[g] && cnt_v[g] == '0 && mode_v[g] && !bus_wr) |=> (!en_v[g] && cnt_v[g] == '0));

        // R6
        pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (pend_v[g] && !bus_wr) |=> pend_v[g]);

        // R7
        busy_second_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(busy_v[g]) |=> busy_v[g]);

        // R7
        busy_end_chk: assert property (@(posedge clk) disable iff (rst)
            (busy_v[g] && $past(busy_v[g])) |=> !busy_v[g]);

        // R9
        mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            mask_v[g] |-> !irq[g]);
    end
endmodule

bind interval_timer_bank tmr_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .bus_wr (bus_wr),
    .irq    (irq),
    .pend_v (pend_v),
    .mask_v (mask_v),
    .busy_v (busy_v),
    .en_v   (en_v),
    .mode_v (mode_v),
    .cnt_v  (cnt_v)
);

// File: tb/interval_timer_bank_tb_top.sv
module interval_timer_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    localparam logic [5:0] A_MODE   = 6'h04;
    localparam logic [5:0] A_LOAD   = 6'h08;
    localparam logic [5:0] A_RUN    = 6'h10;
    localparam logic [5:0] A_RELOAD = 6'h14;
    localparam logic [5:0] A_COUNT  = 6'h18;
    localparam logic [5:0] A_CLEAR  = 6'h20;
    localparam logic [5:0] A_MASK   = 6'h24;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer_bank dut_i (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .irq     (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one write, committed at the next rising edge; returns at the following falling edge
    task automatic wr(input int ch, input logic [5:0] ofs, input logic [31:0] d);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1;
        paddr = 8'(ch * 64) | 8'(ofs);
        pwdata = d;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd_addr(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1;
        d = prdata;
        psel = 1'b0;
    endtask

    task automatic expect_reg(input string req, input int ch, input logic [5:0] ofs,
                              input logic [31:0] exp);
        logic [31:0] d;
        rd_addr(8'(ch * 64) | 8'(ofs), d);
        chk(req, $sformatf("ch%0d ofs 0x%02h", ch, ofs), d, exp);
    endtask

    task automatic expect_status(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd_addr(8'h00, d);
        chk(req, "status word", d, exp);
    endtask

    task automatic quiesce();
        for (int c = 0; c < NCH; c++) wr(c, A_RUN, 32'd0);
        tick(1);
        for (int c = 0; c < NCH; c++) wr(c, A_CLEAR, 32'd1);
        tick(3);
    endtask

    task automatic run_all();
        int lv[5] = '{0, 1, 2, 3, 6};

        // R1: reset state
        for (int c = 0; c < NCH; c++) begin
            expect_reg("R1", c, 6'h00, 32'd0);
            expect_reg("R1", c, A_MODE, 32'd0);
            expect_reg("R1", c, A_LOAD, 32'd0);
            expect_reg("R1", c, A_RUN, 32'd0);
            expect_reg("R1", c, A_RELOAD, 32'd0);
            expect_reg("R1", c, A_COUNT, 32'd0);
            expect_reg("R1", c, A_CLEAR, 32'd0);
            expect_reg("R1", c, A_MASK, 32'd0);
        end
        expect_status("R1", 32'd0);
        chk("R1", "irq", 32'(irq), 32'd0);

        // R11: per-window isolation of load/count
        for (int c = 0; c < NCH; c++) wr(c, A_LOAD, 32'(100 + c * 17));
        for (int c = 0; c < NCH; c++) begin
            expect_reg("R11", c, A_LOAD, 32'(100 + c * 17));
            expect_reg("R11", c, A_COUNT, 32'(100 + c * 17));
            expect_reg("R11", c, A_RUN, 32'd0);
        end

        // R2/R3/R9: continuous sweep over load values
        for (int k = 0; k < 5; k++) begin
            int L;
            int ch;
            int n;
            L  = lv[k];
            ch = k % NCH;
            quiesce();
            wr(ch, A_MODE, 32'd0);
            wr(ch, A_LOAD, 32'(L));
            wr(ch, A_RUN, 32'd1);
            expect_reg("R2", ch, A_COUNT, 32'(L));
            n = 0;
            for (int s = 1; s <= 2 * L + 3; s++) begin
                tick(1);
                n = s;
                expect_reg("R3", ch, A_COUNT, 32'(L - (n % (L + 1))));
                expect_reg("R3", ch, A_CLEAR, (n >= L + 1) ? 32'd1 : 32'd0);
                chk("R9", "irq bit", 32'(irq[ch]), (n >= L + 1) ? 32'd1 : 32'd0);
            end
            wr(ch, A_RUN, 32'd0);
            n = n + 1;
            expect_reg("R2", ch, A_COUNT, 32'(L - (n % (L + 1))));
            tick(3);
            expect_reg("R2", ch, A_COUNT, 32'(L - (n % (L + 1))));
        end

        // R4: single run
        quiesce();
        wr(1, A_MODE, 32'd1);
        wr(1, A_LOAD, 32'd4);
        wr(1, A_RUN, 32'd1);
        for (int s = 1; s <= 5; s++) begin
            tick(1);
            expect_reg("R4", 1, A_COUNT, (s <= 4) ? 32'(4 - s) : 32'd0);
            expect_reg("R4", 1, A_RUN, (s <= 4) ? 32'd1 : 32'd0);
            expect_reg("R4", 1, A_CLEAR, (s <= 4) ? 32'd0 : 32'd1);
        end
        tick(3);
        expect_reg("R4", 1, A_COUNT, 32'd0);
        expect_reg("R4", 1, A_RUN, 32'd0);
        wr(1, A_LOAD, 32'hFFFF_FFFF);
        wr(1, A_RUN, 32'd1);
        tick(3);
        expect_reg("R4", 1, A_COUNT, 32'hFFFF_FFFC);
        wr(1, A_RUN, 32'd0);
        expect_reg("R4", 1, A_COUNT, 32'hFFFF_FFFB);

        // R5: reload with data 0 and data 1
        quiesce();
        wr(2, A_MODE, 32'd0);
        wr(2, A_LOAD, 32'd20);
        wr(2, A_RUN, 32'd1);
        tick(5);
        expect_reg("R5", 2, A_COUNT, 32'd15);
        wr(2, A_RELOAD, 32'd0);
        expect_reg("R5", 2, A_COUNT, 32'd20);
        tick(3);
        expect_reg("R5", 2, A_COUNT, 32'd17);
        wr(2, A_RELOAD, 32'd1);
        expect_reg("R5", 2, A_COUNT, 32'd20);
        wr(2, A_RUN, 32'd0);
        expect_reg("R5", 2, A_COUNT, 32'd19);

        // R6/R7: clear handshake on channel 3 (load 1, expiry every 2 edges)
        quiesce();
        wr(3, A_MODE, 32'd0);
        wr(3, A_LOAD, 32'd1);
        wr(3, A_RUN, 32'd1);
        tick(2);
        expect_reg("R6", 3, A_CLEAR, 32'd1);
        wr(3, A_CLEAR, 32'd1);
        expect_reg("R7", 3, A_CLEAR, 32'd2);
        expect_reg("R7", 3, A_COUNT, 32'd0);
        tick(1);
        expect_reg("R7", 3, A_CLEAR, 32'd3);
        chk("R9", "irq ch3 pending", 32'(irq), 32'h8);
        wr(3, A_CLEAR, 32'd1);
        expect_reg("R7", 3, A_CLEAR, 32'd1);
        wr(3, A_RUN, 32'd0);
        expect_reg("R6", 3, A_CLEAR, 32'd1);
        wr(3, A_CLEAR, 32'd0);
        expect_reg("R6", 3, A_CLEAR, 32'd1);
        wr(3, A_CLEAR, 32'd1);
        expect_reg("R6", 3, A_CLEAR, 32'd2);
        tick(1);
        expect_reg("R7", 3, A_CLEAR, 32'd2);
        tick(1);
        expect_reg("R7", 3, A_CLEAR, 32'd0);

        // R8: clear coinciding with expiry (load 0 expires every edge)
        quiesce();
        wr(0, A_MODE, 32'd0);
        wr(0, A_LOAD, 32'd0);
        wr(0, A_RUN, 32'd1);
        tick(1);
        expect_reg("R8", 0, A_CLEAR, 32'd1);
        wr(0, A_CLEAR, 32'd1);
        expect_reg("R8", 0, A_CLEAR, 32'd3);
        wr(0, A_RUN, 32'd0);

        // R9/R10: mask and status with several channels pending
        quiesce();
        expect_status("R10", 32'd0);
        wr(1, A_MODE, 32'd1);
        wr(1, A_LOAD, 32'd0);
        wr(1, A_RUN, 32'd1);
        tick(1);
        chk("R9", "irq ch1 only", 32'(irq), 32'h2);
        wr(1, A_MASK, 32'd1);
        chk("R9", "irq masked", 32'(irq), 32'h0);
        expect_reg("R9", 1, A_MASK, 32'd1);
        expect_reg("R9", 1, A_CLEAR, 32'd1);
        expect_status("R9", 32'h2);
        wr(1, A_MASK, 32'd0);
        chk("R9", "irq unmasked", 32'(irq), 32'h2);
        wr(2, A_MODE, 32'd1);
        wr(2, A_LOAD, 32'd0);
        wr(2, A_RUN, 32'd1);
        tick(1);
        expect_status("R10", 32'h6);
        chk("R10", "irq ch1+ch2", 32'(irq), 32'h6);
        expect_reg("R11", 0, A_MASK, 32'd0);
        expect_reg("R11", 3, A_CLEAR, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        run_all();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule